// File: doc/BRIEF.md
# Flat Data-Space Access Router

This block sits between the byte-wide data port of a processor core and the three things that live in its single flat data address space. The general-purpose register file occupies the lowest addresses. The I/O register window follows directly after it. External data memory takes every address above that. Each load or store request is decoded combinationally. The block raises the select strobe of exactly one target, and raises that target's write strobe when the request is a store. It also translates the address into the form the target expects: a register index, an I/O port number, or an unchanged memory address.

The I/O port number is the data address minus the register count. I/O accesses made through the data space therefore reach the same port numbers that a dedicated port-access path would use. All targets are synchronous-read. For a load, the target presents its byte in the cycle after the request. The block remembers which target was selected and steers that byte onto its response port, together with a one-cycle valid flag.

Top module: `data_space_router`

## Requirements
- R1: A valid request with address below 32 asserts `rf_sel` and drives `rf_idx` with address bits [4:0].
- R2: A valid request with address from 32 to 95 inclusive asserts `io_sel` and drives `io_port` with the address minus 32.
- R3: A valid request with address 96 or above asserts `mem_sel` and drives `mem_addr` with the address unchanged.
- R4: Exactly one of `rf_sel`, `io_sel` and `mem_sel` is high while `req_valid` is high, and all three are low while it is low.
- R5: The write strobe of the selected target equals `req_we`. The write strobes of unselected targets are low. `tgt_wdata` carries `req_wdata`.
- R6: A load request (`req_valid` high, `req_we` low) gives `rsp_valid` high in the next cycle, with `rsp_rdata` equal to the read-data input of the target selected by that request. In every other cycle `rsp_valid` is low and `rsp_rdata` is zero.
- R7: A store request or an idle cycle produces no response in the following cycle.
- R8: While `rst_n` is low, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Flat data address |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 8 | Load data |
| tgt_wdata | output | 8 | Store data to all targets |
| rf_sel | output | 1 | Register file select |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | 5 | Register index |
| rf_rdata | input | 8 | Register file read data (one cycle after select) |
| io_sel | output | 1 | I/O space select |
| io_we | output | 1 | I/O write strobe |
| io_port | output | 6 | I/O port number |
| io_rdata | input | 8 | I/O read data (one cycle after select) |
| mem_sel | output | 1 | Data memory select |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | 16 | Data memory address |
| mem_rdata | input | 8 | Memory read data (one cycle after select) |

## Verification
The assertions assume that each target returns its byte in exactly the cycle after it is selected. They also assume that the request inputs hold steady from one falling edge to the next. The stimulus drives requests and all three read-data inputs only at falling edges, and it changes the read data every cycle. A stale or wrongly steered byte therefore shows up as a mismatch. Addresses are drawn from each region, around the 31/32 and 95/96 boundaries, and at the top of the address space. Idle cycles are mixed in.

// File: rtl/data_space_router.sv
module data_space_router #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 32,
  parameter int IO_COUNT  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] tgt_wdata,
  output logic              rf_sel,
  output logic              rf_we,
  output logic [$clog2(REG_COUNT)-1:0] rf_idx,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              io_sel,
  output logic              io_we,
  output logic [$clog2(IO_COUNT)-1:0] io_port,
  input  logic [DATA_W-1:0] io_rdata,
  output logic              mem_sel,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W  = $clog2(REG_COUNT);
  localparam int PORT_W = $clog2(IO_COUNT);
  localparam logic [ADDR_W-1:0] IO_BASE  = ADDR_W'(REG_COUNT);
  localparam logic [ADDR_W-1:0] MEM_BASE = ADDR_W'(REG_COUNT + IO_COUNT);

  logic in_rf, in_io;
  logic [ADDR_W-1:0] io_off;
  logic [2:0] hit_q;
  logic       rd_q;

  assign in_rf  = req_addr < IO_BASE;
  assign in_io  = !in_rf && (req_addr < MEM_BASE);
  assign io_off = req_addr - IO_BASE;

  assign rf_sel  = req_valid && in_rf;
  assign io_sel  = req_valid && in_io;
  assign mem_sel = req_valid && !in_rf && !in_io;

  assign rf_we  = rf_sel  && req_we;
  assign io_we  = io_sel  && req_we;
  assign mem_we = mem_sel && req_we;

  assign rf_idx    = req_addr[IDX_W-1:0];
  assign io_port   = io_off[PORT_W-1:0];
  assign mem_addr  = req_addr;
  assign tgt_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      hit_q <= '0;
    end else begin
      rd_q  <= req_valid && !req_we;
      hit_q <= {mem_sel, io_sel, rf_sel};
    end
  end

  assign rsp_valid = rd_q;

  always_comb begin
    rsp_rdata = '0;
    if (rd_q) begin
      unique case (1'b1)
        hit_q[0]: rsp_rdata = rf_rdata;
        hit_q[1]: rsp_rdata = io_rdata;
        hit_q[2]: rsp_rdata = mem_rdata;
        default:  rsp_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/data_space_router_chk.sv
module data_space_router_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 32,
  parameter int IO_COUNT  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rf_sel,
  input logic              rf_we,
  input logic              io_sel,
  input logic              io_we,
  input logic              mem_sel,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  // R1
  rf_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_sel |-> (req_addr < ADDR_W'(REG_COUNT)));
  // R3
  mem_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel |-> (req_addr >= ADDR_W'(REG_COUNT + IO_COUNT)) && (mem_addr == req_addr));
  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({rf_sel, io_sel, mem_sel}) == 1);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(rf_sel || io_sel || mem_sel));
  // R5
  store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || io_we || mem_we) |-> req_we && $onehot0({rf_we, io_we, mem_we}));
  // R6
  load_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);
  // R7
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid && (rsp_rdata == '0));
endmodule

bind data_space_router data_space_router_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .IO_COUNT(IO_COUNT)
) u_chk (.*);

// File: tb/data_space_router_tb.sv
module data_space_router_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic rsp_valid;
  logic [7:0] rsp_rdata, tgt_wdata;
  logic rf_sel, rf_we, io_sel, io_we, mem_sel, mem_we;
  logic [4:0] rf_idx;
  logic [5:0] io_port;
  logic [15:0] mem_addr;
  logic [7:0] rf_rdata = '0, io_rdata = '0, mem_rdata = '0;

  int checks = 0, fails = 0, cycles = 0;
  int pend_q[$];

  always #10 clk = ~clk;

  data_space_router u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // target code: -1 none/store, 0 reg file, 1 io, 2 memory
  task automatic step(input bit v, input bit we, input int a);
    int tgt, pend, exp_d;
    @(negedge clk);
    req_valid = v; req_we = we; req_addr = 16'(a); req_wdata = 8'($urandom);
    rf_rdata = 8'($urandom); io_rdata = 8'($urandom); mem_rdata = 8'($urandom);
    #1;
    tgt = !v ? -1 : (a < 32 ? 0 : (a < 96 ? 1 : 2));
    chk(rf_sel == (tgt == 0), "R1 rf_sel", rf_sel, tgt == 0);
    chk(io_sel == (tgt == 1), "R2 io_sel", io_sel, tgt == 1);
    chk(mem_sel == (tgt == 2), "R3 mem_sel", mem_sel, tgt == 2);
    if (tgt == 0) chk(rf_idx == a, "R1 rf_idx", rf_idx, a);
    if (tgt == 1) chk(io_port == a - 32, "R2 io_port", io_port, a - 32);
    if (tgt == 2) chk(mem_addr == a, "R3 mem_addr", mem_addr, a);
    chk((rf_sel + io_sel + mem_sel) == (v ? 1 : 0), "R4 select count",
        rf_sel + io_sel + mem_sel, v ? 1 : 0);
    chk(rf_we == (tgt == 0 && we) && io_we == (tgt == 1 && we) && mem_we == (tgt == 2 && we),
        "R5 write strobes", {rf_we, io_we, mem_we}, {(tgt == 2 && we), (tgt == 1 && we), (tgt == 0 && we)});
    chk(tgt_wdata == req_wdata, "R5 wdata", tgt_wdata, req_wdata);
    pend = pend_q.pop_front();
    if (pend >= 0) begin
      exp_d = (pend == 0) ? rf_rdata : (pend == 1 ? io_rdata : mem_rdata);
      chk(rsp_valid == 1'b1, "R6 rsp_valid", rsp_valid, 1);
      chk(rsp_rdata == exp_d, "R6 rsp_rdata", rsp_rdata, exp_d);
    end else begin
      chk(rsp_valid == 1'b0, "R7 rsp_valid", rsp_valid, 0);
      chk(rsp_rdata == 8'd0, "R7 rsp_rdata", rsp_rdata, 0);
    end
    pend_q.push_back((v && !we) ? tgt : -1);
  endtask

  initial begin
    int edges[7] = '{0, 31, 32, 95, 96, 200, 65535};
    pend_q.push_back(-1);
    repeat (3) @(negedge clk);
    #1 chk(rsp_valid == 1'b0, "R8 reset rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    foreach (edges[i]) begin
      step(1'b1, 1'b0, edges[i]);
      step(1'b1, 1'b1, edges[i]);
    end
    for (int n = 0; n < 3000; n++) begin
      int a;
      case ($urandom % 4)
        0: a = $urandom % 32;
        1: a = 32 + $urandom % 64;
        2: a = $urandom % 65536;
        default: a = 26 + $urandom % 76;
      endcase
      step(($urandom % 5) != 0, $urandom % 2, a);
    end
    step(1'b0, 1'b0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, 20000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule